// File: doc/BRIEF.md
# Rate 1/3 Parallel-Concatenated Recursive Convolutional Encoder

The encoder turns a stream of information bits into three output streams: the bit itself (systematic) and two parity bits. Each parity bit comes from a 16-state recursive systematic convolutional component with memory 4. The first component encodes the bits in natural order (`in_bit`). The second component encodes a copy of the same data that has already been permuted outside this block and arrives on `in_ilv_bit`. A select input picks one of two generator pairs for both components. The pair is captured when a block opens and is held until the block closes.

Data is framed in sub-blocks of `BLOCK_LEN` bit periods. The last 4 periods of a sub-block are tail periods, so `BLOCK_LEN-4` periods carry information. After the last information bit has been accepted, the block drops `in_ready` and makes 4 tail periods on its own. These tail periods drive the first component back to the all-zero state. The second component is never terminated. It holds its register through the tail and carries that state into the next sub-block, unless a restart is requested together with the start strobe.

The control is a three-state machine. `ST_IDLE` waits for `in_valid` with `in_start`. That accepted bit is the first information bit, and the transition open moves to `ST_DATA`. `ST_DATA` accepts one bit per valid cycle. The transition seal moves to `ST_TAIL` when the bit at index `BLOCK_LEN-5` is accepted. `ST_TAIL` runs 4 cycles and then takes the transition close back to `ST_IDLE`.

Top module: `turbo_encoder`

## Requirements
- R1: After reset, `out_valid`, `out_last`, `out_sys`, `out_par1` and `out_par2` are 0 and `in_ready` is 1.
- R2: An information bit is accepted when `in_valid` is 1 in `ST_DATA`, or when `in_valid` and `in_start` are both 1 in `ST_IDLE`. On the next clock edge `out_valid` is 1 and `out_sys` equals the accepted bit.
- R3: `out_par1` follows the recursive code on `in_bit`. Polynomial bit k is the coefficient of D^k. With register cells r1..r4 and input u, the feedback is a = u xor (xor of g0[k]·rk for k=1..4). The parity is g1[0]·a xor (xor of g1[k]·rk for k=1..4). Then r1 takes a, and rk takes r(k-1). The first component starts from all-zero on every accepted start.
- R4: `out_par2` follows the same code on `in_ilv_bit`. Its register is cleared on an accepted start only when `in_restart2` is 1. Otherwise it continues from where the previous sub-block left it.
- R5: `in_gen_sel` = 0 selects g0 = 17, g1 = 11 (octal). A value of 1 selects g0 = 31, g1 = 33. The value is sampled with the accepted start and ignored for the rest of the sub-block.
- R6: After `BLOCK_LEN-4` accepted information bits, `in_ready` is 0 for exactly 4 cycles. Each of these cycles produces a valid output one cycle later, and `out_last` is 1 only on the fourth one. `in_valid` is ignored during the tail.
- R7: In a tail period the first component's input equals its own feedback. `out_sys` shows that forced input. `out_par2` is 0 and the second register is unchanged. After the fourth tail period the first register is all-zero.
- R8: In `ST_IDLE`, `in_valid` without `in_start` produces no output. In `ST_DATA`, `in_start` has no effect beyond a normal data bit.
- R9: A cycle without acceptance in `ST_DATA` produces no output and leaves both component registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit pair is present |
| in_start | input | 1 | Marks the first information bit of a sub-block |
| in_restart2 | input | 1 | With an accepted start, clears the second component |
| in_gen_sel | input | 1 | Generator pair select, sampled at start |
| in_bit | input | 1 | Information bit, natural order |
| in_ilv_bit | input | 1 | Information bit, permuted order |
| in_ready | output | 1 | Low during the tail periods |
| out_valid | output | 1 | Output triple is valid |
| out_last | output | 1 | Final tail period of the sub-block |
| out_sys | output | 1 | Systematic bit (forced input during the tail) |
| out_par1 | output | 1 | Parity of the first component |
| out_par2 | output | 1 | Parity of the second component (0 during the tail) |

## Verification
In the same cycle, the block can clear the first component, optionally clear the second one, latch the generator pair and encode the first information bit from the cleared state. In that cycle the parity must reflect a fresh register even though the previous sub-block left a non-zero state. This case is provoked by back-to-back sub-blocks: each new start follows the close of the previous block directly, with `in_restart2` set for some blocks and clear for others, and `in_gen_sel` changed between them. The result is judged on every cycle against a behavioural trellis model in the bench. Mid-block noise on `in_gen_sel`, stray starts and writes during the tail are applied at the same time, and all of them must leave the outputs unchanged.

// File: rtl/turbo_enc_pkg.sv
package turbo_enc_pkg;
    localparam int MEM = 4;
    typedef logic [MEM:0] poly_t;
    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_TAIL} enc_state_t;
    localparam poly_t FB_PAIR0 = 5'o17;
    localparam poly_t FF_PAIR0 = 5'o11;
    localparam poly_t FB_PAIR1 = 5'o31;
    localparam poly_t FF_PAIR1 = 5'o33;
endpackage

// File: rtl/rsc_component.sv
module rsc_component
    import turbo_enc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           clear,
    input  logic           force_term,
    input  logic           bit_in,
    input  poly_t          fb_poly,
    input  poly_t          ff_poly,
    output logic           sys_out,
    output logic           par_out,
    output logic [MEM-1:0] state_out
);
    logic [MEM-1:0] sr;
    logic [MEM-1:0] base;
    logic [MEM-1:0] nxt;
    logic           fb;
    logic           u;
    logic           a;

    always_comb begin
        base    = clear ? '0 : sr;
        fb      = ^(fb_poly[MEM:1] & base);
        u       = force_term ? fb : bit_in;
        a       = u ^ fb;
        par_out = (ff_poly[0] & a) ^ (^(ff_poly[MEM:1] & base));
        nxt     = {base[MEM-2:0], a};
        sys_out = u;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    sr <= '0;
        else if (step) sr <= nxt;
    end

    assign state_out = sr;

    // R7: a forced tail step feeds a zero into the first cell
    assert_tail_feeds_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && force_term) |=> (sr[0] == 1'b0));
endmodule

// File: rtl/turbo_encoder.sv
module turbo_encoder
    import turbo_enc_pkg::*;
#(
    parameter int BLOCK_LEN = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_start,
    input  logic in_restart2,
    input  logic in_gen_sel,
    input  logic in_bit,
    input  logic in_ilv_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_last,
    output logic out_sys,
    output logic out_par1,
    output logic out_par2
);
    localparam int TAIL_LEN = MEM;
    localparam int INFO_LEN = BLOCK_LEN - TAIL_LEN;
    localparam int CW       = $clog2(BLOCK_LEN);
    localparam logic [CW-1:0] LAST_INFO = CW'(INFO_LEN - 1);
    localparam logic [CW-1:0] LAST_TAIL = CW'(BLOCK_LEN - 1);

    enc_state_t fsm, fsm_nxt;
    logic [CW-1:0] cnt;
    logic          sel_q;
    logic          sel_now;
    logic          accept;
    logic          tail_step;
    logic          opening;
    poly_t         fb_poly, ff_poly;
    logic          sys1, par1, sys2, par2;
    logic [MEM-1:0] st1, st2;

    always_comb begin
        opening   = (fsm == ST_IDLE) && in_valid && in_start;
        accept    = opening || ((fsm == ST_DATA) && in_valid);
        tail_step = (fsm == ST_TAIL);
        in_ready  = (fsm != ST_TAIL);
        sel_now   = (fsm == ST_IDLE) ? in_gen_sel : sel_q;
        fb_poly   = sel_now ? FB_PAIR1 : FB_PAIR0;
        ff_poly   = sel_now ? FF_PAIR1 : FF_PAIR0;
    end

    always_comb begin
        fsm_nxt = fsm;
        unique case (fsm)
            ST_IDLE: if (opening) fsm_nxt = ST_DATA;
            ST_DATA: if (accept && cnt == LAST_INFO) fsm_nxt = ST_TAIL;
            ST_TAIL: if (cnt == LAST_TAIL) fsm_nxt = ST_IDLE;
            default: fsm_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm   <= ST_IDLE;
            cnt   <= '0;
            sel_q <= 1'b0;
        end else begin
            fsm <= fsm_nxt;
            if (opening) begin
                cnt   <= CW'(1);
                sel_q <= in_gen_sel;
            end else if (fsm_nxt == ST_IDLE) begin
                cnt <= '0;
            end else if (accept || tail_step) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    rsc_component u_enc_nat (
        .clk(clk), .rst_n(rst_n),
        .step(accept || tail_step), .clear(opening), .force_term(tail_step),
        .bit_in(in_bit), .fb_poly(fb_poly), .ff_poly(ff_poly),
        .sys_out(sys1), .par_out(par1), .state_out(st1)
    );

    rsc_component u_enc_ilv (
        .clk(clk), .rst_n(rst_n),
        .step(accept), .clear(opening && in_restart2), .force_term(1'b0),
        .bit_in(in_ilv_bit), .fb_poly(fb_poly), .ff_poly(ff_poly),
        .sys_out(sys2), .par_out(par2), .state_out(st2)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_sys   <= 1'b0;
            out_par1  <= 1'b0;
            out_par2  <= 1'b0;
        end else begin
            out_valid <= accept || tail_step;
            out_last  <= tail_step && (cnt == LAST_TAIL);
            out_sys   <= (accept || tail_step) && sys1;
            out_par1  <= (accept || tail_step) && par1;
            out_par2  <= accept && par2 && (sys2 == in_ilv_bit);
        end
    end

    assert_last_zero_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (st1 == '0));
    assert_last_is_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    assert_tail_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_TAIL) |=> out_valid);
    assert_sel_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm != ST_IDLE) && ($past(fsm) != ST_IDLE)) |-> $stable(sel_q));
    assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm == ST_IDLE) && in_valid && !in_start) |=> !out_valid);
    assert_bubble_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(st2));
endmodule

// File: tb/test_turbo_encoder.sv
module test_turbo_encoder;
    localparam int BLOCK_LEN = 4096;
    localparam int INFO_LEN  = BLOCK_LEN - 4;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_start, in_restart2, in_gen_sel, in_bit, in_ilv_bit;
    logic in_ready, out_valid, out_last, out_sys, out_par1, out_par2;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    turbo_encoder #(.BLOCK_LEN(BLOCK_LEN)) i_turbo_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_restart2(in_restart2), .in_gen_sel(in_gen_sel), .in_bit(in_bit),
        .in_ilv_bit(in_ilv_bit), .in_ready(in_ready), .out_valid(out_valid),
        .out_last(out_last), .out_sys(out_sys), .out_par1(out_par1), .out_par2(out_par2)
    );

    // behavioural reference: 0 idle, 1 data, 2 tail
    int      m_mode = 0;
    int      m_cnt  = 0;
    bit      m_sel  = 1'b0;
    bit [3:0] reg1 = '0;
    bit [3:0] reg2 = '0;
    bit e_valid, e_last, e_sys, e_p1, e_p2;
    int e_mode;

    function automatic void code_step(input bit [4:0] g0, input bit [4:0] g1,
                                      inout bit [3:0] r, input bit u_in,
                                      input bit term, output bit sys, output bit par);
        bit fb = 1'b0;
        bit u, a;
        bit p;
        for (int k = 1; k <= 4; k++) if (g0[k]) fb ^= r[k-1];
        u = term ? fb : u_in;
        a = u ^ fb;
        p = g1[0] & a;
        for (int k = 1; k <= 4; k++) if (g1[k]) p ^= r[k-1];
        r   = {r[2:0], a};
        sys = u;
        par = p;
    endfunction

    task automatic check(input bit act, input bit exp, input string tag, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cycle(input bit v, input bit st, input bit rs, input bit gs,
                         input bit b, input bit ib);
        bit acc, tail, sel_now, s, p;
        bit [4:0] g0, g1;
        in_valid = v; in_start = st; in_restart2 = rs; in_gen_sel = gs;
        in_bit = b; in_ilv_bit = ib;
        check(in_ready, m_mode != 2, "R6", "in_ready");
        acc  = v && ((m_mode == 0 && st) || m_mode == 1);
        tail = (m_mode == 2);
        sel_now = (m_mode == 0) ? gs : m_sel;
        g0 = sel_now ? 5'o31 : 5'o17;
        g1 = sel_now ? 5'o33 : 5'o11;
        if (acc && m_mode == 0) begin
            reg1 = '0;
            if (rs) reg2 = '0;
            m_sel = gs;
        end
        e_mode = m_mode;
        e_valid = acc || tail;
        e_sys = 0; e_p1 = 0; e_p2 = 0;
        e_last = tail && (m_cnt == BLOCK_LEN - 1);
        if (e_valid) begin
            code_step(g0, g1, reg1, b, tail, s, p);
            e_sys = s; e_p1 = p;
        end
        if (acc) begin
            code_step(g0, g1, reg2, ib, 1'b0, s, p);
            e_p2 = p;
        end
        if (acc && m_mode == 0) begin
            m_mode = 1; m_cnt = 1;
        end else if (acc && m_mode == 1) begin
            if (m_cnt == INFO_LEN - 1) m_mode = 2;
            m_cnt++;
        end else if (tail) begin
            if (m_cnt == BLOCK_LEN - 1) begin m_mode = 0; m_cnt = 0; end
            else m_cnt++;
        end
        @(posedge clk);
        @(negedge clk);
        check(out_valid, e_valid, (e_mode == 0) ? "R8" : "R9", "out_valid");
        check(out_sys, e_sys, (e_mode == 2) ? "R7" : "R2", "out_sys");
        check(out_par1, e_p1, m_sel ? "R5" : "R3", "out_par1");
        check(out_par2, e_p2, (e_mode == 2) ? "R7" : "R4", "out_par2");
        check(out_last, e_last, "R6", "out_last");
    endtask

    task automatic run_block(input bit gs, input bit rs, input int bubble_pct);
        int tail_seen = 0;
        cycle(1'b1, 1'b1, rs, gs, 1'($urandom), 1'($urandom));
        while (m_mode == 1) begin
            bit v = ($urandom % 100) >= bubble_pct;
            // stray start and noisy select mid-block: R8, R5
            cycle(v, ($urandom % 50) == 0, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom));
        end
        while (m_mode == 2) begin
            // input offered during the tail is ignored: R6
            cycle(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (out_last) tail_seen++;
        end
        n_tests++;
        if (tail_seen != 1) begin
            n_fail++;
            $display("FAIL R6 last count: actual %0d expected 1", tail_seen);
        end
    endtask

    initial begin
        #(8 * 60000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        rst_n = 1'b0;
        in_valid = 0; in_start = 0; in_restart2 = 0; in_gen_sel = 0; in_bit = 0; in_ilv_bit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(out_valid, 1'b0, "R1", "out_valid");
        check(out_last, 1'b0, "R1", "out_last");
        check(out_sys | out_par1 | out_par2, 1'b0, "R1", "data");
        check(in_ready, 1'b1, "R1", "in_ready");
        // R8: idle valid without start
        for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, 1'b1, 1'($urandom), 1'($urandom), 1'($urandom));
        run_block(1'b0, 1'b1, 20);
        // back-to-back, second component carried over (R4), other pair (R5)
        run_block(1'b1, 1'b0, 0);
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        run_block(1'b0, 1'b0, 40);
        run_block(1'b1, 1'b1, 10);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule